// File: doc/BRIEF.md
# High-Throughput Signal Field CRC Checker

This block checks the high-throughput signal field after it has been decoded to bits. It receives the field as a serial stream: a single-cycle start pulse opens a field, and each valid strobe then delivers one bit in transmission order. The first 34 bits are payload. They pass through an 8-stage CRC register that is preloaded with all ones. The next 8 bits are the transmitted check value. The last 6 bits are tail bits, which must be zero.

The received check bits are compared, one per bit, with the inverted register contents, most significant stage first. When the 48th bit of the field has been taken, the block raises a one-cycle completion pulse. In the same cycle it publishes two verdicts, check-value match and tail clean, together with the captured 34-bit payload. A new start pulse at any point aborts the field in progress and begins a fresh one.

Top module: `htsig_crc_check`

## Requirements
- R1: While rst_ni is low and after its release, done_o, crc_ok_o and tail_ok_o are 0 and field_o is all zeros. The block is idle.
- R2: A start_i pulse opens a field and preloads every CRC stage with 1. If bit_valid_i is high in the same cycle as start_i, that bit is field bit 0.
- R3: Field bits 0..33 update the register once per valid bit, as follows. Stage k takes stage k-1 for k = 3..7. With f = stage7 xor bit, stage2 takes stage1 xor f, stage1 takes stage0 xor f, and stage0 takes f. Cycles in which bit_valid_i is low change nothing.
- R4: Field bits 34..41 are compared in order with the inverse of stages 7, 6, …, 0. crc_ok_o is 1 at completion only if all eight match.
- R5: Field bits 42..47 are tail bits. tail_ok_o is 1 at completion only if all six are 0.
- R6: done_o is high for exactly one cycle, the cycle after the 48th valid bit is taken. crc_ok_o, tail_ok_o and field_o take their new values in that same cycle.
- R7: crc_ok_o and tail_ok_o keep their values after completion until the next start_i. They read 0 from the cycle after that start until the next completion.
- R8: A start_i during an open field discards it. No done_o is issued for the discarded field, and counting restarts at bit 0.
- R9: Valid bits that arrive while no field is open are ignored. They change no output.
- R10: field_o holds payload bit i on bit i. It changes only when done_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new field (one-cycle pulse) |
| bit_valid_i | input | 1 | bit_i carries a field bit this cycle |
| bit_i | input | 1 | Serial field bit |
| done_o | output | 1 | One-cycle field-complete pulse |
| crc_ok_o | output | 1 | Received check value matched |
| tail_ok_o | output | 1 | All tail bits were zero |
| field_o | output | 34 | Captured payload bits |

## Verification
The bench computes the check value from the stated update equations and sends fields that are correct, fields with one check bit flipped, and fields with a single set tail bit. A swapped stage order, missing inversion, or misplaced phase boundary therefore shows up as a wrong verdict. Fields are also sent with idle gaps between bits, and with the first bit arriving in the same cycle as the start pulse. A design that counts idle cycles, or drops that first bit, would shift the whole field. A field is aborted part-way and then restarted. A design that forgets the abort gives an extra or early completion pulse. After completion, stray bits are sent and a new start is issued. A design that keeps counting after the field, or clears its verdicts at the wrong time, changes the outputs when it should not.

// File: rtl/htsig_crc_pkg.sv
package htsig_crc_pkg;
  localparam int unsigned DATA_BITS = 34;
  localparam int unsigned CRC_BITS  = 8;
  localparam int unsigned TAIL_BITS = 6;
  localparam int unsigned FIELD_BITS = DATA_BITS + CRC_BITS + TAIL_BITS;
  localparam int unsigned CNT_W = $clog2(FIELD_BITS + 1);

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_CHECK = 2'd1,
    PH_TAIL  = 2'd2
  } phase_e;
endpackage

// File: rtl/htsig_field_seq.sv
module htsig_field_seq #(
  parameter int unsigned DATA_BITS = 34,
  parameter int unsigned CRC_BITS  = 8,
  parameter int unsigned TAIL_BITS = 6,
  localparam int unsigned FIELD_BITS = DATA_BITS + CRC_BITS + TAIL_BITS,
  localparam int unsigned CNT_W = $clog2(FIELD_BITS + 1),
  localparam int unsigned IDX_W = (CRC_BITS > 1) ? $clog2(CRC_BITS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      bit_valid_i,
  output logic                      take_o,
  output logic                      last_o,
  output htsig_crc_pkg::phase_e     phase_o,
  output logic [CNT_W-1:0]          pos_o,
  output logic [IDX_W-1:0]          chk_idx_o
);
  import htsig_crc_pkg::*;

  localparam logic [CNT_W-1:0] LastPos  = CNT_W'(FIELD_BITS - 1);
  localparam logic [CNT_W-1:0] CheckPos = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] TailPos  = CNT_W'(DATA_BITS + CRC_BITS);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             open_w;
  logic [CNT_W-1:0] pos_w;
  logic [CNT_W-1:0] rel_w;

  // a start in this cycle opens the field before the bit is taken
  assign open_w = start_i | active_q;
  assign pos_w  = start_i ? '0 : cnt_q;
  assign take_o = open_w & bit_valid_i;
  assign last_o = take_o & (pos_w == LastPos);
  assign pos_o  = pos_w;
  assign rel_w  = pos_w - CheckPos;
  assign chk_idx_o = rel_w[IDX_W-1:0];

  always_comb begin
    if (pos_w < CheckPos)     phase_o = PH_DATA;
    else if (pos_w < TailPos) phase_o = PH_CHECK;
    else                      phase_o = PH_TAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take_o) begin
      active_q <= ~last_o;
      cnt_q    <= last_o ? '0 : pos_w + CNT_W'(1);
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end
  end
endmodule

// File: rtl/htsig_crc_lfsr.sv
module htsig_crc_lfsr #(
  parameter int unsigned      CRC_BITS  = 8,
  parameter logic [CRC_BITS-1:0] FB_MASK = 8'h07
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic [CRC_BITS-1:0] crc_o
);
  logic [CRC_BITS-1:0] crc_q;
  logic [CRC_BITS-1:0] base_w;
  logic [CRC_BITS-1:0] step_w;
  logic                fb_w;

  assign base_w = init_i ? '1 : crc_q;
  assign fb_w   = base_w[CRC_BITS-1] ^ bit_i;

  // Galois form: shift up, feedback into stages selected by FB_MASK
  for (genvar k = 0; k < CRC_BITS; k++) begin : g_stage
    if (k == 0) begin : g_lsb
      assign step_w[k] = FB_MASK[k] & fb_w;
    end else begin : g_up
      assign step_w[k] = base_w[k-1] ^ (FB_MASK[k] & fb_w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (shift_i) crc_q <= step_w;
    else              crc_q <= base_w;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/htsig_crc_check.sv
module htsig_crc_check #(
  parameter int unsigned DATA_BITS = htsig_crc_pkg::DATA_BITS,
  parameter int unsigned CRC_BITS  = htsig_crc_pkg::CRC_BITS,
  parameter int unsigned TAIL_BITS = htsig_crc_pkg::TAIL_BITS,
  parameter logic [CRC_BITS-1:0] FB_MASK = 8'h07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 bit_valid_i,
  input  logic                 bit_i,
  output logic                 done_o,
  output logic                 crc_ok_o,
  output logic                 tail_ok_o,
  output logic [DATA_BITS-1:0] field_o
);
  import htsig_crc_pkg::*;

  localparam int unsigned FIELD_BITS = DATA_BITS + CRC_BITS + TAIL_BITS;
  localparam int unsigned CNT_W = $clog2(FIELD_BITS + 1);
  localparam int unsigned IDX_W = (CRC_BITS > 1) ? $clog2(CRC_BITS) : 1;

  logic             take_w;
  logic             last_w;
  phase_e           phase_w;
  logic [CNT_W-1:0] pos_w;
  logic [IDX_W-1:0] chk_idx_w;
  logic [CRC_BITS-1:0] crc_w;

  logic                 crc_err_q;
  logic                 tail_err_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 chk_bad_w;
  logic                 tail_bad_w;

  htsig_field_seq #(
    .DATA_BITS (DATA_BITS),
    .CRC_BITS  (CRC_BITS),
    .TAIL_BITS (TAIL_BITS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .take_o      (take_w),
    .last_o      (last_w),
    .phase_o     (phase_w),
    .pos_o       (pos_w),
    .chk_idx_o   (chk_idx_w)
  );

  htsig_crc_lfsr #(
    .CRC_BITS (CRC_BITS),
    .FB_MASK  (FB_MASK)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (start_i),
    .shift_i (take_w && phase_w == PH_DATA),
    .bit_i   (bit_i),
    .crc_o   (crc_w)
  );

  // received check bit must equal inverted stage, top stage first
  assign chk_bad_w  = take_w && phase_w == PH_CHECK &&
                      (bit_i == crc_w[IDX_W'(CRC_BITS-1) - chk_idx_w]);
  assign tail_bad_w = take_w && phase_w == PH_TAIL && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_err_q  <= 1'b0;
      tail_err_q <= 1'b0;
      data_q     <= '0;
      done_o     <= 1'b0;
      crc_ok_o   <= 1'b0;
      tail_ok_o  <= 1'b0;
      field_o    <= '0;
    end else begin
      done_o <= last_w;
      if (start_i) begin
        crc_err_q  <= chk_bad_w;
        tail_err_q <= tail_bad_w;
        crc_ok_o   <= 1'b0;
        tail_ok_o  <= 1'b0;
      end else begin
        crc_err_q  <= crc_err_q | chk_bad_w;
        tail_err_q <= tail_err_q | tail_bad_w;
      end
      if (take_w && phase_w == PH_DATA)
        data_q[pos_w[$clog2(DATA_BITS)-1:0]] <= bit_i;
      if (last_w) begin
        crc_ok_o  <= ~(crc_err_q | chk_bad_w);
        tail_ok_o <= ~(tail_err_q | tail_bad_w);
        field_o   <= data_q;
      end
    end
  end
endmodule

// File: rtl/htsig_crc_check_sva.sv
module htsig_crc_check_sva #(
  parameter int unsigned DATA_BITS = htsig_crc_pkg::DATA_BITS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 bit_valid_i,
  input logic                 bit_i,
  input logic                 done_o,
  input logic                 crc_ok_o,
  input logic                 tail_ok_o,
  input logic [DATA_BITS-1:0] field_o
);
  import htsig_crc_pkg::*;

  localparam logic [CNT_W-1:0] FullCnt = CNT_W'(FIELD_BITS);

  // independent count of bits taken since the last start
  logic             open_q;
  logic [CNT_W-1:0] seen_q;
  logic             seen_full_w;

  assign seen_full_w = (seen_q == FullCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      seen_q <= '0;
    end else if (start_i) begin
      open_q <= ~(bit_valid_i && FIELD_BITS == 1);
      seen_q <= bit_valid_i ? CNT_W'(1) : '0;
    end else if (open_q && bit_valid_i) begin
      seen_q <= seen_q + CNT_W'(1);
      open_q <= (seen_q + CNT_W'(1)) != FullCnt;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> seen_full_w && !$past(start_i)); // R8

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !crc_ok_o && !tail_ok_o && !done_o); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(start_i)) |-> ($stable(crc_ok_o) && $stable(tail_ok_o))); // R7

  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(field_o)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !done_o && !crc_ok_o && !tail_ok_o); // R1

  logic unused_w;
  assign unused_w = bit_i;
endmodule

bind htsig_crc_check htsig_crc_check_sva #(.DATA_BITS(DATA_BITS)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .done_o      (done_o),
  .crc_ok_o    (crc_ok_o),
  .tail_ok_o   (tail_ok_o),
  .field_o     (field_o)
);

// File: tb/htsig_crc_check_bench.sv
module htsig_crc_check_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vld = 1'b0;
  logic bdat = 1'b0;
  logic done;
  logic crc_ok;
  logic tail_ok;
  logic [33:0] field;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  htsig_crc_check u_htsig_crc_check (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .bit_valid_i (vld),
    .bit_i       (bdat),
    .done_o      (done),
    .crc_ok_o    (crc_ok),
    .tail_ok_o   (tail_ok),
    .field_o     (field)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [33:0] d);
    logic [7:0] c = 8'hFF;
    logic fb;
    for (int i = 0; i < 34; i++) begin
      fb = c[7] ^ d[i];
      c = {c[6:2], c[1] ^ fb, c[0] ^ fb, fb};
    end
    return ~c;
  endfunction

  function automatic logic [47:0] make_field(input logic [33:0] d);
    logic [47:0] f = '0;
    logic [7:0] k = ref_crc(d);
    f[33:0] = d;
    for (int j = 0; j < 8; j++) f[34+j] = k[7-j];
    return f;
  endfunction

  // at a negedge on entry and exit
  task automatic send_bit(input logic b, input bit with_start);
    start = with_start;
    vld = 1'b1;
    bdat = b;
    @(negedge clk);
    start = 1'b0;
    vld = 1'b0;
    bdat = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_field(input logic [47:0] f, input int gap, input bit start_with_bit);
    if (!start_with_bit) pulse_start();
    for (int i = 0; i < 48; i++) begin
      send_bit(f[i], start_with_bit && i == 0);
      if (i != 47) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 crc_ok", crc_ok, 0);
    chk("R1 tail_ok", tail_ok, 0);
    chk("R1 field", field, 0);
  endtask

  task automatic t_good(input logic [33:0] d, input int gap, input bit swb, input string tag);
    int d0 = done_cnt;
    send_field(make_field(d), gap, swb);
    chk({tag, " R6 done pulse"}, done, 1);
    chk({tag, " R4 crc_ok"}, crc_ok, 1);
    chk({tag, " R5 tail_ok"}, tail_ok, 1);
    chk({tag, " R10 field"}, field, d);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, done, 0);
    chk({tag, " R7 flags held"}, {crc_ok, tail_ok}, 2'b11);
    chk({tag, " R6 done count"}, done_cnt - d0, 1);
  endtask

  task automatic t_start_clears();
    pulse_start();
    chk("R7 start clears crc_ok", crc_ok, 0);
    chk("R7 start clears tail_ok", tail_ok, 0);
  endtask

  task automatic t_bad_crc(input logic [33:0] d, input int k);
    logic [47:0] f = make_field(d);
    f[34+k] = ~f[34+k];
    send_field(f, 0, 0);
    chk("R4 corrupted check bit", crc_ok, 0);
    chk("R4 tail still clean", tail_ok, 1);
    chk("R4 done", done, 1);
    @(negedge clk);
  endtask

  task automatic t_bad_tail(input logic [33:0] d, input int k);
    logic [47:0] f = make_field(d);
    f[42+k] = 1'b1;
    send_field(f, 0, 0);
    chk("R5 tail bit set", tail_ok, 0);
    chk("R5 crc still ok", crc_ok, 1);
    chk("R10 field after bad tail", field, d);
    @(negedge clk);
  endtask

  task automatic t_abort(input logic [33:0] d);
    int d0 = done_cnt;
    logic [47:0] junk = make_field(~d);
    pulse_start();
    for (int i = 0; i < 40; i++) send_bit(junk[i], 0);
    t_good(d, 0, 0, "R8 after abort");
    chk("R8 single done across abort", done_cnt - d0, 1);
  endtask

  task automatic t_idle(input logic [33:0] d);
    int d0 = done_cnt;
    for (int i = 0; i < 60; i++) send_bit(i[0], 0);
    @(negedge clk);
    chk("R9 no done while idle", done_cnt - d0, 0);
    chk("R9 field unchanged", field, d);
    chk("R9 flags unchanged", {crc_ok, tail_ok}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good(34'h2_5A5A_C3C1, 0, 0, "R2 R3 pattern A");
    t_start_clears();
    t_good(34'h0_0000_0000, 0, 0, "R3 zeros");
    t_good(34'h3_FFFF_FFFF, 0, 0, "R3 ones");
    t_good(34'h1_2345_6789, 2, 0, "R3 gaps");
    t_good(34'h2_F0E1_D2C3, 0, 1, "R2 bit with start");
    t_bad_crc(34'h1_2345_6789, 0);
    t_bad_crc(34'h2_5A5A_C3C1, 7);
    t_bad_tail(34'h0_BEEF_0001, 5);
    t_bad_tail(34'h3_0101_0101, 0);
    t_abort(34'h1_C0DE_4242);
    t_idle(34'h1_C0DE_4242);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule